// File: doc/BRIEF.md
# Semaphore Release and Reduction Unit

This block carries out semaphore updates on a single 32-bit word in memory. Software-side logic loads three configuration registers through a narrow write port: the upper part of the target address, the lower word-aligned part, and a payload. A write to the fourth, trigger register starts the operation it encodes. The unit then talks to memory through a request port that holds each request until it is acknowledged.

A release stores the payload at the target address without reading it first. A reduction reads the current word, combines it with the payload, and writes the result back to the same address. The available operators are min, max, xor, and, or, add, a bounded increment and a bounded decrement. A signed or unsigned mode applies to min and max. Trigger codes the unit does not support finish at once and make no memory access. While an operation is in flight the unit reports busy and drops any further trigger.

Top module: `sem_unit`

## Requirements
- R1: After reset `busy_o`, `done_o` and `mem_req_o` are low.
- R2: Configuration writes select by `cfg_sel_i`: 0 upper address byte (data bits 7:0), 1 lower address (data bits 31:2 kept), 2 payload, 3 trigger. The memory address is {upper byte, lower bits 31:2, 2'b00}, 40 bits.
- R3: In the trigger word, bits 4:0 hold the operation code (2 release, 16 reduction), bits 30:27 hold the operator (0 min, 1 max, 2 xor, 3 and, 4 or, 5 add, 6 inc, 7 dec), and bit 31 holds the format (0 signed, 1 unsigned).
- R4: A release makes exactly one memory write of the payload and no read.
- R5: A reduction makes one read and then one write, both at the same address, and the write carries the combined value.
- R6: Min and max compare as signed when the format bit is 0 and as unsigned when it is 1.
- R7: Xor, and, or and add ignore the format bit, and add wraps modulo 2^32.
- R8: Inc writes mem+1 when mem < payload (unsigned), otherwise 0.
- R9: Dec writes mem−1 when mem is nonzero and mem <= payload (unsigned), otherwise the payload.
- R10: An operation code other than 2 or 16, or a reduction whose operator is 8 or higher, makes no memory access and pulses `done_o` in the cycle after the trigger.
- R11: `busy_o` rises in the cycle after an accepted trigger and stays high until the final write is acknowledged. A trigger during busy is dropped. Address and payload are captured when the trigger is accepted.
- R12: A request keeps its address, direction and data stable until `mem_ack_i`. `done_o` is a one-cycle pulse in the cycle after the final acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | Operation completed (one-cycle pulse) |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 40 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata_i | input | 32 | Read data |

## Verification
Every reduction operator is run on operand pairs chosen so that a wrong operator, a wrong signedness or a wrong comparison bound gives a different result. A negative memory word against a small positive payload separates signed from unsigned min and max. The increment and decrement vectors sit on both sides of their bounds: equal to the payload, one below it, zero, and all ones. Release, unsupported codes and an overlapping trigger are then driven directly, with memory latency varied, to show how many reads and writes each produces and at which address.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [2:0] {
    RED_MIN = 3'd0, RED_MAX = 3'd1, RED_XOR = 3'd2, RED_AND = 3'd3,
    RED_OR  = 3'd4, RED_ADD = 3'd5, RED_INC = 3'd6, RED_DEC = 3'd7
  } red_op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} sem_st_e;

  localparam logic [4:0] OPC_RELEASE = 5'd2;
  localparam logic [4:0] OPC_REDUCE  = 5'd16;

  localparam logic [1:0] SEL_ADDR_HI = 2'd0;
  localparam logic [1:0] SEL_ADDR_LO = 2'd1;
  localparam logic [1:0] SEL_PAYLOAD = 2'd2;
  localparam logic [1:0] SEL_TRIGGER = 2'd3;
endpackage

// File: rtl/sem_alu.sv
module sem_alu
  import sem_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  red_op_e           op_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] pay_i,
  output logic [DATA_W-1:0] res_o
);
  logic mem_lt_s, mem_lt_u;

  assign mem_lt_s = $signed(mem_i) < $signed(pay_i);
  assign mem_lt_u = mem_i < pay_i;

  always_comb begin
    unique case (op_i)
      RED_MIN: res_o = (signed_i ? mem_lt_s : mem_lt_u) ? mem_i : pay_i;
      RED_MAX: res_o = (signed_i ? mem_lt_s : mem_lt_u) ? pay_i : mem_i;
      RED_XOR: res_o = mem_i ^ pay_i;
      RED_AND: res_o = mem_i & pay_i;
      RED_OR:  res_o = mem_i | pay_i;
      RED_ADD: res_o = mem_i + pay_i;
      RED_INC: res_o = mem_lt_u ? mem_i + 1'b1 : '0;
      RED_DEC: res_o = ((mem_i != '0) && !(pay_i < mem_i)) ? mem_i - 1'b1 : pay_i;
      default: res_o = pay_i;
    endcase
  end

  // bounded counters never exceed the payload
  always_comb begin
    if (op_i == RED_INC) a_r8_inc_bound: assert (!(pay_i < res_o));
    if (op_i == RED_DEC) a_r9_dec_bound: assert (!(pay_i < res_o));
  end
endmodule

// File: rtl/sem_regs.sv
module sem_regs
  import sem_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_HI_W = 8,
  localparam int unsigned AW       = DATA_W + ADDR_HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [AW-1:0]     addr_o,
  output logic [DATA_W-1:0] pay_o,
  output logic              trig_o,
  output logic [DATA_W-1:0] trig_word_o
);
  logic [ADDR_HI_W-1:0] hi_q;
  logic [DATA_W-3:0]    lo_q;
  logic [DATA_W-1:0]    pay_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      pay_q <= '0;
    end else if (we_i) begin
      case (sel_i)
        SEL_ADDR_HI: hi_q  <= wdata_i[ADDR_HI_W-1:0];
        SEL_ADDR_LO: lo_q  <= wdata_i[DATA_W-1:2];
        SEL_PAYLOAD: pay_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign addr_o      = {hi_q, lo_q, 2'b00};
  assign pay_o       = pay_q;
  assign trig_o      = we_i && (sel_i == SEL_TRIGGER);
  assign trig_word_o = wdata_i;

  a_r2_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(addr_o) && $stable(pay_o));
endmodule

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_HI_W = 8,
  localparam int unsigned AW       = DATA_W + ADDR_HI_W,
  localparam int unsigned FMT_BIT  = DATA_W - 1,
  localparam int unsigned OPER_HI  = DATA_W - 2,
  localparam int unsigned OPER_LO  = DATA_W - 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [DATA_W-1:0] trig_word_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] pay_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o
);
  sem_st_e           st_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] pay_q, mem_q, alu_res;
  red_op_e           oper_q;
  logic              sgn_q, is_red_q, done_q;

  logic [4:0] opc;
  logic [3:0] oper;
  logic       accept, is_rel, is_red;

  assign opc    = trig_word_i[4:0];
  assign oper   = trig_word_i[OPER_HI:OPER_LO];
  assign accept = trig_i && (st_q == ST_IDLE);
  assign is_rel = (opc == OPC_RELEASE);
  assign is_red = (opc == OPC_REDUCE) && !oper[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      pay_q    <= '0;
      mem_q    <= '0;
      oper_q   <= RED_MIN;
      sgn_q    <= 1'b0;
      is_red_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          addr_q   <= addr_i;
          pay_q    <= pay_i;
          oper_q   <= red_op_e'(oper[2:0]);
          sgn_q    <= !trig_word_i[FMT_BIT];
          is_red_q <= is_red;
          if (is_rel)      st_q <= ST_WRITE;
          else if (is_red) st_q <= ST_READ;
          else             done_q <= 1'b1;
        end
        ST_READ: if (mem_ack_i) begin
          mem_q <= mem_rdata_i;
          st_q  <= ST_WRITE;
        end
        ST_WRITE: if (mem_ack_i) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  sem_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (oper_q),
    .signed_i(sgn_q),
    .mem_i   (mem_q),
    .pay_i   (pay_q),
    .res_o   (alu_res)
  );

  assign mem_req_o   = (st_q != ST_IDLE);
  assign mem_we_o    = (st_q == ST_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = is_red_q ? alu_res : pay_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;

  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r4_release_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> is_red_q);

  a_r11_busy_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(mem_we_o && mem_ack_i) |=> busy_o);

  a_r12_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r10_unsupported_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !is_rel && !is_red |=> !mem_req_o && done_o);

  a_r5_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ack_i |=> mem_req_o && mem_we_o
                                          && $stable(mem_addr_o));
endmodule

// File: rtl/sem_unit.sv
module sem_unit
  import sem_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_HI_W = 8,
  localparam int unsigned AW       = DATA_W + ADDR_HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [AW-1:0]     cfg_addr;
  logic [DATA_W-1:0] cfg_pay, trig_word;
  logic              trig;

  sem_regs #(.DATA_W(DATA_W), .ADDR_HI_W(ADDR_HI_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .wdata_i    (cfg_wdata_i),
    .addr_o     (cfg_addr),
    .pay_o      (cfg_pay),
    .trig_o     (trig),
    .trig_word_o(trig_word)
  );

  sem_ctrl #(.DATA_W(DATA_W), .ADDR_HI_W(ADDR_HI_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig),
    .trig_word_i(trig_word),
    .addr_i     (cfg_addr),
    .pay_i      (cfg_pay),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_ack_i  (mem_ack_i),
    .mem_rdata_i(mem_rdata_i),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );
endmodule

// File: tb/sem_unit_bench.sv
module sem_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cfg_we_i;
  logic [1:0]  cfg_sel_i;
  logic [31:0] cfg_wdata_i;
  logic        busy_o, done_o, mem_req_o, mem_we_o, mem_ack_i;
  logic [39:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sem_unit u_sem_unit (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i,
    .busy_o, .done_o, .mem_req_o, .mem_we_o, .mem_addr_o,
    .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );

  typedef struct packed {
    logic [31:0] pay;
    logic [31:0] mem;
    logic [31:0] exp;
    logic [3:0]  oper;
    logic        fmt;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0005, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd0, 1'b0}, // R6 min signed
    '{32'h0000_0005, 32'hFFFF_FFFF, 32'h0000_0005, 4'd0, 1'b1}, // R6 min unsigned
    '{32'h0000_0005, 32'hFFFF_FFFF, 32'h0000_0005, 4'd1, 1'b0}, // R6 max signed
    '{32'h0000_0005, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd1, 1'b1}, // R6 max unsigned
    '{32'h8000_0000, 32'h0000_0003, 32'h8000_0000, 4'd0, 1'b0}, // R6 min signed, negative payload
    '{32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'hFF00_FF00, 4'd2, 1'b1}, // R7 xor
    '{32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'h00F0_00F0, 4'd3, 1'b0}, // R7 and
    '{32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'hFFF0_FFF0, 4'd4, 1'b1}, // R7 or
    '{32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001, 4'd5, 1'b0}, // R7 add wraps
    '{32'h0000_0010, 32'h0000_0020, 32'h0000_0030, 4'd5, 1'b1}, // R7 add unsigned fmt
    '{32'h0000_000A, 32'h0000_0003, 32'h0000_0004, 4'd6, 1'b0}, // R8 inc below
    '{32'h0000_000A, 32'h0000_000A, 32'h0000_0000, 4'd6, 1'b0}, // R8 inc at bound
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 4'd6, 1'b0}, // R8 inc unsigned compare
    '{32'h0000_000A, 32'h0000_0005, 32'h0000_0004, 4'd7, 1'b0}, // R9 dec below
    '{32'h0000_000A, 32'h0000_0000, 32'h0000_000A, 4'd7, 1'b0}, // R9 dec from zero
    '{32'h0000_000A, 32'h0000_000B, 32'h0000_000A, 4'd7, 1'b0}, // R9 dec above bound
    '{32'h0000_000A, 32'h0000_000A, 32'h0000_0009, 4'd7, 1'b1}  // R9 dec at bound
  };

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] data);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  function automatic logic [31:0] trig_word(input logic [4:0] opc,
                                            input logic [3:0] oper, input logic fmt);
    return {fmt, oper, 22'd0, opc};
  endfunction

  // issues a trigger and services memory; starts and ends on a falling edge
  task automatic run_op(input logic [31:0] trig, input logic [31:0] mem_val,
                        input int lat, output int n_rd, output int n_wr,
                        output logic [39:0] raddr, output logic [39:0] waddr,
                        output logic [31:0] wval, output bit stable, output bit saw_done);
    logic [39:0] a0;
    logic        w0;
    n_rd = 0; n_wr = 0; raddr = '0; waddr = '0; wval = '0;
    stable = 1'b1; saw_done = 1'b0;
    cfg_wr(2'd3, trig);
    for (int c = 0; c < 40; c++) begin
      if (done_o) begin saw_done = 1'b1; break; end
      if (mem_req_o) begin
        a0 = mem_addr_o; w0 = mem_we_o;
        for (int l = 0; l < lat; l++) @(negedge clk_i);
        if (mem_addr_o !== a0 || mem_we_o !== w0 || !mem_req_o) stable = 1'b0;
        if (mem_we_o) begin n_wr++; waddr = mem_addr_o; wval = mem_wdata_o; end
        else          begin n_rd++; raddr = mem_addr_o; end
        mem_ack_i = 1'b1; mem_rdata_i = mem_val;
        @(negedge clk_i);
        mem_ack_i = 1'b0; mem_rdata_i = '0;
      end else begin
        @(negedge clk_i);
      end
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    summary();
  end

  initial begin
    int          nr, nw;
    logic [39:0] ra, wa;
    logic [31:0] wv;
    bit          st, dn;

    rst_ni = 1'b0; cfg_we_i = 1'b0; cfg_sel_i = '0; cfg_wdata_i = '0;
    mem_ack_i = 1'b0; mem_rdata_i = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!busy_o && !done_o && !mem_req_o, "R1 reset outputs",
          {busy_o, done_o, mem_req_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 address formation, R4 release
    cfg_wr(2'd0, 32'h0000_01A5);
    cfg_wr(2'd1, 32'h1234_5677);
    cfg_wr(2'd2, 32'hCAFE_0001);
    run_op(trig_word(5'd2, 4'd5, 1'b0), 32'hDEAD_BEEF, 2, nr, nw, ra, wa, wv, st, dn);
    check(wa == 40'hA5_1234_5674, "R2 address", wa, 40'hA5_1234_5674);
    check(nr == 0 && nw == 1, "R4 access count", {nr[15:0], nw[15:0]}, 32'h0000_0001);
    check(wv == 32'hCAFE_0001, "R4 payload written", wv, 32'hCAFE_0001);
    check(st && dn, "R12 hold and done", {st, dn}, 2'b11);

    // R5 read-modify-write, R3 field decode via table below
    cfg_wr(2'd2, 32'h0000_0007);
    run_op(trig_word(5'd16, 4'd5, 1'b0), 32'h0000_0010, 3, nr, nw, ra, wa, wv, st, dn);
    check(nr == 1 && nw == 1, "R5 access count", {nr[15:0], nw[15:0]}, 32'h0001_0001);
    check(ra == 40'hA5_1234_5674 && wa == ra, "R5 same address", wa, ra);
    check(wv == 32'h17, "R5 combined value", wv, 32'h17);
    check(st, "R12 request stable", st, 1);

    // R3 R6 R7 R8 R9 operator table
    for (int i = 0; i < NV; i++) begin
      cfg_wr(2'd2, VEC[i].pay);
      run_op(trig_word(5'd16, VEC[i].oper, VEC[i].fmt), VEC[i].mem, i % 3,
             nr, nw, ra, wa, wv, st, dn);
      check(nr == 1 && nw == 1 && wv == VEC[i].exp && dn,
            $sformatf("R3 operator vector %0d", i), wv, VEC[i].exp);
    end

    // R10 unsupported codes: acquire, acquire-geq, operator 9
    run_op(trig_word(5'd1, 4'd0, 1'b0), 32'h0, 0, nr, nw, ra, wa, wv, st, dn);
    check(nr == 0 && nw == 0 && dn, "R10 acquire code", {nr[15:0], nw[15:0]}, 0);
    run_op(trig_word(5'd4, 4'd0, 1'b0), 32'h0, 0, nr, nw, ra, wa, wv, st, dn);
    check(nr == 0 && nw == 0 && dn, "R10 acquire-geq code", {nr[15:0], nw[15:0]}, 0);
    run_op(trig_word(5'd16, 4'd9, 1'b0), 32'h0, 0, nr, nw, ra, wa, wv, st, dn);
    check(nr == 0 && nw == 0 && dn, "R10 operator 9", {nr[15:0], nw[15:0]}, 0);
    @(negedge clk_i);
    check(!done_o && !busy_o, "R10 done single cycle", done_o, 0);

    // R11 busy blocks trigger, captured config
    cfg_wr(2'd2, 32'h0000_0055);
    cfg_wr(2'd3, trig_word(5'd2, 4'd0, 1'b0));
    check(busy_o && mem_req_o && mem_we_o, "R11 busy after trigger", busy_o, 1);
    cfg_wr(2'd3, trig_word(5'd16, 4'd5, 1'b0));
    cfg_wr(2'd2, 32'h0000_0099);
    cfg_wr(2'd1, 32'h0000_0100);
    check(busy_o && mem_we_o, "R11 trigger dropped while busy", mem_we_o, 1);
    check(mem_wdata_o == 32'h55, "R11 payload captured", mem_wdata_o, 32'h55);
    check(mem_addr_o == 40'hA5_1234_5674, "R11 address captured", mem_addr_o,
          40'hA5_1234_5674);
    mem_ack_i = 1'b1;
    @(negedge clk_i);
    mem_ack_i = 1'b0;
    check(done_o && !busy_o, "R12 done after ack", {done_o, busy_o}, 2'b10);
    @(negedge clk_i);
    check(!done_o, "R12 done pulse width", done_o, 0);
    begin
      bit quiet = 1'b1;
      for (int c = 0; c < 5; c++) begin
        if (mem_req_o || busy_o) quiet = 1'b0;
        @(negedge clk_i);
      end
      check(quiet, "R11 dropped trigger not replayed", quiet, 1);
    end

    summary();
  end
endmodule